// File: doc/BRIEF.md
# PCI Express Capability Locator

This block locates the PCI Express capability structure in a 256-byte PCI configuration space and reports how large a data payload the function can take. On a start pulse it reads the capabilities head pointer and then follows the chain of capability headers. Each header gives an ID and the offset of the next header. When it reaches ID 0x10 it reads two more registers of that structure. The supported payload code comes from the low three bits of the dword at +4. The payload code the host has programmed comes from bits 7..5 of the dword at +8.

All traffic goes through a simple read port. The block raises a one-cycle request with a dword address and then waits for a data-valid strobe, so any read latency of one cycle or more is accepted. When the walk ends, a one-cycle done pulse is raised. The results are the structure's byte offset, both payload sizes as byte counts, a found flag and a flag for reserved payload codes. They stay valid until the next start. The walk gives up with found low in three cases: the chain ends, it points back into the fixed header region below 0x40, or it runs longer than a fixed hop limit (which breaks circular lists).

Top module: `expcap_walker`

## Requirements
- R1: After reset, rdReq, done, found and payloadErr are low, and capOffset, payloadSup and payloadCur are zero.
- R2: A start pulse while idle causes one read of dword address 13 (byte 0x34). Bits 7..0 of that dword are the byte offset of the first capability header.
- R3: Every followed pointer has its two low bits forced to zero. A header is read at dword address pointer/4. Its bits 7..0 are the capability ID and its bits 15..8 are the next pointer.
- R4: A header with ID 0x10 ends the search. capOffset becomes that header's byte offset. The block then reads dword pointer/4+1 and then dword pointer/4+2.
- R5: payloadSup is 2^(n+7) bytes, with n taken from bits 2..0 of the dword at +4. payloadCur is 2^(m+7) bytes, with m taken from bits 7..5 of the dword at +8. Both are 13-bit byte counts, so code 0 gives 128 and code 5 gives 4096.
- R6: A payload code of 6 or 7 sets payloadErr and gives 0 on that payload output. found stays high.
- R7: A head or next pointer below 0x40 (zero included) ends the walk with done and found low. capOffset, both payloads and payloadErr are then zero.
- R8: At most 48 capability headers are read in one walk. If the 48th is not ID 0x10, the walk ends as not-found.
- R9: rdReq is high for exactly one cycle per read, and the next request waits until rdValid has been seen. Results are the same for any read latency of one cycle or more.
- R10: done is a one-cycle pulse. Results hold until the next start. A start while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| rdReq | output | 1 | One-cycle configuration read request |
| rdAddr | output | 6 | Dword address of the read |
| rdValid | input | 1 | Read data valid strobe |
| rdData | input | 32 | Read data dword |
| done | output | 1 | One-cycle end-of-walk pulse |
| found | output | 1 | PCI Express capability located |
| capOffset | output | 8 | Byte offset of the located structure |
| payloadSup | output | 13 | Supported maximum payload in bytes |
| payloadCur | output | 13 | Programmed maximum payload in bytes |
| payloadErr | output | 1 | A payload code was reserved (6 or 7) |

## Verification
The hardest case to reach is the hop limit. A well-formed list can never hit it, so the bench builds a two-entry loop in configuration space whose next pointers point at each other. The walk must then stop after exactly 48 header reads. The bench also sets the low pointer bits and places junk in unused dword bits, so that masking and field selection are observed at the read-address port. The same chains are run with different read latencies and with a second start pulse in the middle of a walk.

// File: rtl/capwalk_pkg.sv
package capwalk_pkg;

  localparam int CFG_AW = 6;
  localparam logic [CFG_AW-1:0] HEAD_DW = 6'd13;
  localparam logic [7:0] LIST_FLOOR = 8'h40;
  localparam logic [2:0] MAX_CODE = 3'd5;

  typedef struct packed {
    logic clrAll;
    logic selHead;
    logic followHead;
    logic followNext;
    logic markCap;
    logic storeSup;
    logic storeCur;
  } walkCmd_t;

  typedef struct packed {
    logic idMatch;
    logic headBad;
    logic nextBad;
    logic hopLast;
  } walkFlag_t;

endpackage

// File: rtl/capwalk_ctrl.sv
module capwalk_ctrl
  import capwalk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      rdValid,
  input  walkFlag_t flags,
  output walkCmd_t  cmd,
  output logic      rdReq,
  output logic      done
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;
  typedef enum logic [1:0] {P_HEAD, P_HDR, P_DCAP, P_DCTL} phase_t;

  state_t state, stateNxt;
  phase_t phase, phaseNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= P_HEAD;
    end else begin
      state <= stateNxt;
      phase <= phaseNxt;
    end
  end

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    phaseNxt = phase;
    rdReq    = 1'b0;
    done     = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          cmd.clrAll  = 1'b1;
          cmd.selHead = 1'b1;
          phaseNxt    = P_HEAD;
          stateNxt    = S_ISSUE;
        end
      end
      S_ISSUE: begin
        rdReq    = 1'b1;
        stateNxt = S_WAIT;
      end
      S_WAIT: begin
        if (rdValid) begin
          unique case (phase)
            P_HEAD: begin
              if (flags.headBad) stateNxt = S_DONE;
              else begin
                cmd.followHead = 1'b1;
                phaseNxt       = P_HDR;
                stateNxt       = S_ISSUE;
              end
            end
            P_HDR: begin
              if (flags.idMatch) begin
                cmd.markCap = 1'b1;
                phaseNxt    = P_DCAP;
                stateNxt    = S_ISSUE;
              end else if (flags.nextBad || flags.hopLast) begin
                stateNxt = S_DONE;
              end else begin
                cmd.followNext = 1'b1;
                stateNxt       = S_ISSUE;
              end
            end
            P_DCAP: begin
              cmd.storeSup = 1'b1;
              phaseNxt     = P_DCTL;
              stateNxt     = S_ISSUE;
            end
            default: begin
              cmd.storeCur = 1'b1;
              stateNxt     = S_DONE;
            end
          endcase
        end
      end
      default: begin
        done     = 1'b1;
        stateNxt = S_IDLE;
      end
    endcase
  end

  // R9
  single_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R10
  single_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !rdReq);

endmodule

// File: rtl/capwalk_dp.sv
module capwalk_dp
  import capwalk_pkg::*;
#(
  parameter int HOP_LIMIT = 48,
  parameter int PAY_W = 13,
  parameter logic [7:0] PCIE_ID = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCmd_t          cmd,
  input  logic [31:0]       rdData,
  output walkFlag_t         flags,
  output logic [CFG_AW-1:0] rdAddr,
  output logic              found,
  output logic [7:0]        capOffset,
  output logic [PAY_W-1:0]  payloadSup,
  output logic [PAY_W-1:0]  payloadCur,
  output logic              payloadErr
);

  localparam int HOP_W = (HOP_LIMIT > 1) ? $clog2(HOP_LIMIT) : 1;
  localparam logic [HOP_W-1:0] HOP_END = HOP_W'(HOP_LIMIT - 1);

  logic [CFG_AW-1:0] addrReg;
  logic [HOP_W-1:0]  hopCnt;
  logic [7:0]        capOffReg;
  logic [2:0]        supCode, curCode;
  logic              foundReg;
  logic [7:0]        headPtr, nextPtr;

  assign headPtr = {rdData[7:2], 2'b00};
  assign nextPtr = {rdData[15:10], 2'b00};

  assign flags.idMatch = (rdData[7:0] == PCIE_ID);
  assign flags.headBad = (headPtr < LIST_FLOOR);
  assign flags.nextBad = (nextPtr < LIST_FLOOR);
  assign flags.hopLast = (hopCnt == HOP_END);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      hopCnt    <= '0;
      capOffReg <= '0;
      supCode   <= '0;
      curCode   <= '0;
      foundReg  <= 1'b0;
    end else begin
      if (cmd.clrAll) begin
        hopCnt    <= '0;
        capOffReg <= '0;
        supCode   <= '0;
        curCode   <= '0;
        foundReg  <= 1'b0;
      end
      if (cmd.selHead) addrReg <= HEAD_DW;
      if (cmd.followHead) begin
        addrReg <= headPtr[7:2];
        hopCnt  <= '0;
      end
      if (cmd.followNext) begin
        addrReg <= nextPtr[7:2];
        hopCnt  <= hopCnt + 1'b1;
      end
      if (cmd.markCap) begin
        capOffReg <= {addrReg, 2'b00};
        addrReg   <= addrReg + 1'b1;
      end
      if (cmd.storeSup) begin
        supCode <= rdData[2:0];
        addrReg <= addrReg + 1'b1;
      end
      if (cmd.storeCur) begin
        curCode  <= rdData[7:5];
        foundReg <= 1'b1;
      end
    end
  end

  logic [2:0]       codeSel [2];
  logic [PAY_W-1:0] payOut  [2];
  assign codeSel[0] = supCode;
  assign codeSel[1] = curCode;

  for (genvar g = 0; g < 2; g++) begin : g_pay
    assign payOut[g] = (foundReg && codeSel[g] <= MAX_CODE)
                     ? (PAY_W'(1) << ({1'b0, codeSel[g]} + 4'd7)) : '0;
  end

  assign rdAddr     = addrReg;
  assign found      = foundReg;
  assign capOffset  = capOffReg;
  assign payloadSup = payOut[0];
  assign payloadCur = payOut[1];
  assign payloadErr = foundReg && (supCode > MAX_CODE || curCode > MAX_CODE);

  // R8
  hop_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    hopCnt <= HOP_END);

  // R4
  cap_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    found |-> (capOffset >= LIST_FLOOR && capOffset[1:0] == 2'b00));

  // R10
  found_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (found && !cmd.clrAll) |=> found);

endmodule

// File: rtl/expcap_walker.sv
module expcap_walker
  import capwalk_pkg::*;
#(
  parameter int HOP_LIMIT = 48,
  parameter int PAY_W = 13,
  parameter logic [7:0] PCIE_ID = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              rdReq,
  output logic [CFG_AW-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [31:0]       rdData,
  output logic              done,
  output logic              found,
  output logic [7:0]        capOffset,
  output logic [PAY_W-1:0]  payloadSup,
  output logic [PAY_W-1:0]  payloadCur,
  output logic              payloadErr
);

  walkCmd_t  cmd;
  walkFlag_t flags;

  capwalk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rdValid(rdValid),
    .flags(flags), .cmd(cmd), .rdReq(rdReq), .done(done)
  );

  capwalk_dp #(.HOP_LIMIT(HOP_LIMIT), .PAY_W(PAY_W), .PCIE_ID(PCIE_ID)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdData(rdData), .flags(flags),
    .rdAddr(rdAddr), .found(found), .capOffset(capOffset),
    .payloadSup(payloadSup), .payloadCur(payloadCur), .payloadErr(payloadErr)
  );

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdAddr == HEAD_DW || rdAddr >= LIST_FLOOR[7:2]));

endmodule

// File: tb/tb_expcap_walker.sv
module tb_expcap_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        rdReq;
  logic [5:0]  rdAddr;
  logic        rdValid;
  logic [31:0] rdData;
  logic        done, found, payloadErr;
  logic [7:0]  capOffset;
  logic [12:0] payloadSup, payloadCur;

  always #10 clk = ~clk;

  expcap_walker dut (
    .clk(clk), .rstN(rstN), .start(start), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .done(done), .found(found),
    .capOffset(capOffset), .payloadSup(payloadSup), .payloadCur(payloadCur),
    .payloadErr(payloadErr)
  );

  logic [31:0] cfg [64];
  int expAddr[$];
  int lat = 1;
  int nChecks = 0;
  int nFail = 0;
  bit doneAllowed = 0;
  int eFound, eOff, eSup, eCur, eErr;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearCfg();
    for (int i = 0; i < 64; i++) cfg[i] = 32'h5A5A0000 + i;
    cfg[13] = 32'h12345600;
  endtask

  task automatic setHdr(input int off, input int id, input int nxt);
    cfg[off/4] = {16'hA5C3, nxt[7:0], id[7:0]};
  endtask

  function automatic int payBytes(input int code);
    return (code <= 5) ? (1 << (code + 7)) : 0;
  endfunction

  // behavioural reference of the walk
  task automatic buildExp();
    int ptr, nxt, hops, sc, cc;
    expAddr.delete();
    eFound = 0; eOff = 0; eSup = 0; eCur = 0; eErr = 0;
    sc = 0; cc = 0; hops = 0;
    expAddr.push_back(13);
    ptr = int'(cfg[13][7:0]) & 'hFC;
    while (ptr >= 'h40) begin
      expAddr.push_back(ptr / 4);
      hops++;
      if (cfg[ptr/4][7:0] == 8'h10) begin
        eFound = 1; eOff = ptr;
        expAddr.push_back(ptr / 4 + 1);
        expAddr.push_back(ptr / 4 + 2);
        sc = int'(cfg[ptr/4 + 1][2:0]);
        cc = int'(cfg[ptr/4 + 2][7:5]);
        break;
      end
      nxt = int'(cfg[ptr/4][15:8]) & 'hFC;
      if (nxt < 'h40 || hops == 48) break;
      ptr = nxt;
    end
    if (eFound != 0) begin
      eSup = payBytes(sc);
      eCur = payBytes(cc);
      eErr = (sc > 5 || cc > 5) ? 1 : 0;
    end
  endtask

  // read-port responder with adjustable latency; checks each request address
  initial begin
    int a;
    rdValid = 1'b0;
    rdData  = '0;
    forever begin
      @(negedge clk);
      while (rdReq === 1'b1) begin
        a = int'(rdAddr);
        if (expAddr.size() == 0) check("R9 unexpected read", a, -1);
        else check("R3 read address", a, expAddr.pop_front());
        repeat (lat) @(negedge clk);
        check("R9 no second request while waiting", int'(rdReq), 0);
        rdValid = 1'b1;
        rdData  = cfg[a];
        @(negedge clk);
        rdValid = 1'b0;
        rdData  = 32'hDEADBEEF;
      end
    end
  end

  // per-clock monitor for done
  initial begin
    forever begin
      @(negedge clk);
      if (done === 1'b1 && !doneAllowed) check("R10 unexpected done", 1, 0);
    end
  end

  task automatic runWalk(input string tag, input int latency, input bit poke);
    lat = latency;
    buildExp();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    doneAllowed = 1;
    while (done !== 1'b1) @(negedge clk);
    doneAllowed = 0;
    check({tag, " found"}, int'(found), eFound);
    check({tag, " capOffset"}, int'(capOffset), eOff);
    check({tag, " payloadSup"}, int'(payloadSup), eSup);
    check({tag, " payloadCur"}, int'(payloadCur), eCur);
    check({tag, " payloadErr"}, int'(payloadErr), eErr);
    check({tag, " all reads issued"}, expAddr.size(), 0);
    @(negedge clk);
    check("R10 done one cycle", int'(done), 0);
    check("R10 results held", int'(capOffset), eOff);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    clearCfg();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdReq", int'(rdReq), 0);
    check("R1 done", int'(done), 0);
    check("R1 found", int'(found), 0);
    check("R1 capOffset", int'(capOffset), 0);
    check("R1 payloads", int'(payloadSup) + int'(payloadCur), 0);
    check("R1 payloadErr", int'(payloadErr), 0);

    // R2 R4 R5: three-entry chain, latency 1
    clearCfg();
    cfg[13] = 32'h12345640;
    setHdr('h40, 'h01, 'h48);
    setHdr('h48, 'h05, 'h58);
    setHdr('h58, 'h10, 'h00);
    cfg['h5C/4] = 32'h00288FC2;
    cfg['h60/4] = 32'h00002810;
    runWalk("R4 R5 chain", 1, 0);
    check("R5 supported 512", int'(payloadSup), 512);
    check("R5 programmed 128", int'(payloadCur), 128);

    // R9 R10: same chain, latency 3, start while busy
    runWalk("R9 R10 slow reads", 3, 1);

    // R7: chain ends without ID 0x10
    cfg['h58/4] = {16'h0, 8'h00, 8'h11};
    runWalk("R7 list end", 2, 0);

    // R7: head pointer zero
    clearCfg();
    runWalk("R7 head zero", 1, 0);

    // R3 R5: masked low pointer bits, codes 5 and 1
    clearCfg();
    cfg[13] = 32'hFFFFFF43;
    setHdr('h40, 'h09, 'h4B);
    setHdr('h48, 'h10, 'h00);
    cfg['h4C/4] = 32'hFFFFFFF5;
    cfg['h50/4] = 32'hFFFFFF3F;
    runWalk("R3 R5 masked", 2, 0);
    check("R5 supported 4096", int'(payloadSup), 4096);
    check("R5 programmed 256", int'(payloadCur), 256);

    // R6: reserved codes at the top of the space
    clearCfg();
    cfg[13] = 32'h000000F0;
    setHdr('hF0, 'h10, 'h44);
    cfg['hF4/4] = 32'h00000006;
    cfg['hF8/4] = 32'h000000E0;
    runWalk("R6 reserved", 1, 0);
    check("R6 err flag", int'(payloadErr), 1);

    // R7: pointer into the fixed header region
    clearCfg();
    cfg[13] = 32'h00000040;
    setHdr('h40, 'h01, 'h20);
    runWalk("R7 low pointer", 1, 0);

    // R8: circular list
    clearCfg();
    cfg[13] = 32'h00000040;
    setHdr('h40, 'h02, 'h44);
    setHdr('h44, 'h03, 'h40);
    runWalk("R8 loop", 1, 0);

    // R10: results of a found walk survive idle cycles
    clearCfg();
    cfg[13] = 32'h00000080;
    setHdr('h80, 'h10, 'h00);
    cfg['h84/4] = 32'h00000003;
    cfg['h88/4] = 32'h00000040;
    runWalk("R5 R10 single", 2, 0);
    repeat (5) @(negedge clk);
    check("R10 held supported", int'(payloadSup), 1024);
    check("R10 held programmed", int'(payloadCur), 512);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule